// File: doc/BRIEF.md
# Power-Down and Wakeup Controller

This block controls the low-power state of a chip built around an embedded CPU. Software asks for power-down by writing a command bit. The controller then drops the oscillator enable, the PLL enable and the CPU run indication. While the chip is asleep it watches three wakeup sources:

- activity on the host bus;
- a dedicated wakeup pin;
- a second pin that software may instead assign to general-purpose I/O.

An enabled source that becomes active starts a fixed restart order. The oscillator comes back first. After a stability wait the PLL is enabled. After a lock wait the CPU is released and receives a one-cycle wakeup interrupt. Each of the two waits ends on the matching ready input or on a programmable timeout, whichever comes first. A sticky status flag records which sources caused the wakeup. The sequence does not depend on whether the host bus is attached.

Software reaches the block through a small write port. The top module contains all the registers, the input synchronizers, the source decoding and the restart sequencer.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After reset, `osc_en`, `pll_en` and `cpu_run` are 1, `wake_irq` is 0 and `wake_status` is 0. In the configuration register, all source enables, both polarity bits and the general-purpose mode bit reset to 0.
- R2: Writing address 0 with data bit 0 = 1 while running drives `osc_en`, `pll_en` and `cpu_run` low from the next cycle. A write with bit 0 = 0 has no effect.
- R3: Wakeup runs in a fixed order: `osc_en` rises first, `pll_en` rises later, and then `wake_irq` pulses for exactly one cycle. `cpu_run` is high in the pulse cycle and stays high afterwards.
- R4: `pll_en` rises max(L,1) cycles after `osc_en`, where L is the oscillator limit at address 3. If `osc_stable` is high it rises after 1 cycle.
- R5: `wake_irq` is asserted max(P,1) cycles after `pll_en` rises, where P is the PLL limit at address 4. If `pll_lock` is high it is asserted after 1 cycle.
- R6: Configuration register (address 1) bits 0, 1 and 2 enable, in that order, bus activity (`bus_active`, active high), the dedicated pin (`wake_pin`) and the second pin (`wake2_pin`). A disabled source never wakes the block.
- R7: Configuration bit 4 selects active-high for `wake_pin` and bit 5 does the same for `wake2_pin`. The value 0, which is the reset value, means active low.
- R8: While configuration bit 6 is 1, `wake2_pin` is a general-purpose I/O. It causes no wakeup and sets no status flag.
- R9: `wake_status` bits 0, 1 and 2 (bus, dedicated pin, second pin) record every enabled source that is active when the wakeup starts. The bits are sticky. Writing 1 to a bit at address 2 clears it, and a bit written 0 keeps its value.
- R10: If an enabled source is already active when power-down is requested, the block still enters power-down and starts the wakeup at once. With bus activity, `osc_en` is low for exactly one cycle.
- R11: The pins pass through a two-flop synchronizer. `osc_en` rises at the third clock edge after a pin becomes active. For `bus_active` it rises at the first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| bus_active | input | 1 | Host bus activity indication, active high |
| wake_pin | input | 1 | Dedicated wakeup pin, asynchronous |
| wake2_pin | input | 1 | Second wakeup / general-purpose pin, asynchronous |
| osc_stable | input | 1 | Oscillator stable indication |
| pll_lock | input | 1 | PLL lock indication |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_run | output | 1 | CPU released from power-down |
| wake_irq | output | 1 | One-cycle wakeup interrupt |
| wake_status | output | 3 | Sticky wakeup cause flags |

## Verification
The hardest case to reach from the ports is a source that is already active when the power-down command arrives. The block must still drop the clocks for one cycle and then restart, rather than missing the wake or staying in the run state. The stimulus holds `bus_active` high with its enable set, issues the command, and measures the low pulse on `osc_en`. A second hard case is a general-purpose-mode pin that is held active. The stimulus keeps that pin active through a real bus-triggered wakeup, so the status register can show that it was ignored.

// File: rtl/pwk_pkg.sv
package pwk_pkg;

    localparam int NSRC   = 3;
    localparam int SRC_BUS = 0;
    localparam int SRC_PIN = 1;
    localparam int SRC_PIN2 = 2;

    localparam logic [2:0] A_PWR  = 3'd0;
    localparam logic [2:0] A_CFG  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_OLIM = 3'd3;
    localparam logic [2:0] A_PLIM = 3'd4;

    typedef struct packed {
        logic            pin2_gpio;
        logic            pin2_hi;
        logic            pin_hi;
        logic [NSRC-1:0] en;
    } wake_cfg_t;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SLEEP,
        ST_OSC,
        ST_PLL,
        ST_IRQ
    } pwk_state_t;

    // A wait ends once cnt+1 reaches the limit; a limit of 0 behaves like 1.
    function automatic logic wait_done(input logic [15:0] cnt, input logic [15:0] lim);
        logic [16:0] nxt;
        nxt = {1'b0, cnt} + 17'd1;
        return nxt >= {1'b0, lim};
    endfunction

    function automatic logic pin_active(input logic lvl, input logic hi);
        return hi ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/pwk_sync.sv
module pwk_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else if (s == 0) stg[s] <= d;
                else stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwk_detect.sv
module pwk_detect
    import pwk_pkg::*;
(
    input  wake_cfg_t      cfg,
    input  logic           bus_active,
    input  logic           pin_s,
    input  logic           pin2_s,
    output logic [NSRC-1:0] hits,
    output logic           wake_req
);
    logic [NSRC-1:0] raw;

    always_comb begin
        raw[SRC_BUS]  = bus_active;
        raw[SRC_PIN]  = pin_active(pin_s, cfg.pin_hi);
        raw[SRC_PIN2] = pin_active(pin2_s, cfg.pin2_hi) & ~cfg.pin2_gpio;
        hits          = raw & cfg.en;
        wake_req      = |hits;
    end
endmodule

// File: rtl/pwk_regs.sv
module pwk_regs
    import pwk_pkg::*;
#(
    parameter int          CNT_W     = 16,
    parameter int          ADDR_W    = 3,
    parameter logic [15:0] OLIM_RST  = 16'd8,
    parameter logic [15:0] PLIM_RST  = 16'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              capture,
    input  logic [NSRC-1:0]   hits,
    output wake_cfg_t         cfg,
    output logic [CNT_W-1:0]  osc_lim,
    output logic [CNT_W-1:0]  pll_lim,
    output logic              pd_cmd,
    output logic [NSRC-1:0]   status
);
    logic sel_cfg, sel_stat, sel_olim, sel_plim;

    assign sel_cfg  = reg_we && (reg_addr == ADDR_W'(A_CFG));
    assign sel_stat = reg_we && (reg_addr == ADDR_W'(A_STAT));
    assign sel_olim = reg_we && (reg_addr == ADDR_W'(A_OLIM));
    assign sel_plim = reg_we && (reg_addr == ADDR_W'(A_PLIM));
    assign pd_cmd   = reg_we && (reg_addr == ADDR_W'(A_PWR)) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            osc_lim <= CNT_W'(OLIM_RST);
            pll_lim <= CNT_W'(PLIM_RST);
        end else begin
            if (sel_cfg) begin
                cfg.en        <= reg_wdata[NSRC-1:0];
                cfg.pin_hi    <= reg_wdata[4];
                cfg.pin2_hi   <= reg_wdata[5];
                cfg.pin2_gpio <= reg_wdata[6];
            end
            if (sel_olim) osc_lim <= reg_wdata;
            if (sel_plim) pll_lim <= reg_wdata;
        end
    end

    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) status[i] <= 1'b0;
                else if (capture && hits[i]) status[i] <= 1'b1;
                else if (sel_stat && reg_wdata[i]) status[i] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pwk_seq.sv
module pwk_seq
    import pwk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_cmd,
    input  logic             wake_req,
    input  logic             osc_stable,
    input  logic             pll_lock,
    input  logic [CNT_W-1:0] osc_lim,
    input  logic [CNT_W-1:0] pll_lim,
    output logic             osc_en,
    output logic             pll_en,
    output logic             cpu_run,
    output logic             wake_irq,
    output logic             capture
);
    pwk_state_t       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;

    always_comb begin
        st_nx  = st;
        cnt_nx = '0;
        unique case (st)
            ST_RUN:   if (pd_cmd) st_nx = ST_SLEEP;
            ST_SLEEP: if (wake_req) st_nx = ST_OSC;
            ST_OSC: begin
                if (osc_stable || wait_done(16'(cnt), 16'(osc_lim))) st_nx = ST_PLL;
                else cnt_nx = cnt + 1'b1;
            end
            ST_PLL: begin
                if (pll_lock || wait_done(16'(cnt), 16'(pll_lim))) st_nx = ST_IRQ;
                else cnt_nx = cnt + 1'b1;
            end
            ST_IRQ:   st_nx = ST_RUN;
            default:  st_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_RUN;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    assign capture  = (st == ST_SLEEP) && wake_req;
    assign osc_en   = (st != ST_SLEEP);
    assign pll_en   = (st == ST_RUN) || (st == ST_PLL) || (st == ST_IRQ);
    assign cpu_run  = (st == ST_RUN) || (st == ST_IRQ);
    assign wake_irq = (st == ST_IRQ);
endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
    import pwk_pkg::*;
#(
    parameter int          CNT_W    = 16,
    parameter int          ADDR_W   = 3,
    parameter int          SYNC_N   = 2,
    parameter logic [15:0] OLIM_RST = 16'd8,
    parameter logic [15:0] PLIM_RST = 16'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              bus_active,
    input  logic              wake_pin,
    input  logic              wake2_pin,
    input  logic              osc_stable,
    input  logic              pll_lock,
    output logic              osc_en,
    output logic              pll_en,
    output logic              cpu_run,
    output logic              wake_irq,
    output logic [2:0]        wake_status
);
    wake_cfg_t        cfg;
    logic [CNT_W-1:0] osc_lim, pll_lim;
    logic             pd_cmd, capture, wake_req;
    logic [NSRC-1:0]  hits;
    logic [1:0]       pins_s;

    pwk_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .d({wake2_pin, wake_pin}), .q(pins_s)
    );

    pwk_detect u_detect (
        .cfg(cfg), .bus_active(bus_active), .pin_s(pins_s[0]),
        .pin2_s(pins_s[1]), .hits(hits), .wake_req(wake_req)
    );

    pwk_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .OLIM_RST(OLIM_RST),
               .PLIM_RST(PLIM_RST)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .capture(capture), .hits(hits), .cfg(cfg),
        .osc_lim(osc_lim), .pll_lim(pll_lim), .pd_cmd(pd_cmd), .status(wake_status)
    );

    pwk_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .pd_cmd(pd_cmd), .wake_req(wake_req),
        .osc_stable(osc_stable), .pll_lock(pll_lock), .osc_lim(osc_lim),
        .pll_lim(pll_lim), .osc_en(osc_en), .pll_en(pll_en), .cpu_run(cpu_run),
        .wake_irq(wake_irq), .capture(capture)
    );
endmodule

// File: rtl/pwk_checker.sv
module pwk_checker (
    input logic       clk,
    input logic       rst,
    input logic       osc_en,
    input logic       pll_en,
    input logic       cpu_run,
    input logic       wake_irq,
    input logic [2:0] wake_status
);
    // R3: the PLL never runs without the oscillator
    a_r3_pll_needs_osc: assert property (@(posedge clk) disable iff (rst)
        pll_en |-> osc_en);

    // R3: the PLL is switched on only after the oscillator was already on
    a_r3_osc_first: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> $past(osc_en));

    // R3: the CPU runs only with both clocks enabled
    a_r3_run_clocks: assert property (@(posedge clk) disable iff (rst)
        cpu_run |-> (osc_en && pll_en));

    // R3: the interrupt lasts one cycle and is followed by running
    a_r3_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        wake_irq |=> (!wake_irq && cpu_run));

    // R5: the interrupt comes after at least one cycle with the PLL enabled
    a_r5_irq_after_pll: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> $past(pll_en));

    // R9: a status flag is set only out of the power-down state
    a_r9_flag_from_sleep: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_status[0]) || $rose(wake_status[1]) || $rose(wake_status[2])
            |-> !$past(osc_en));
endmodule

bind pwrdn_wake_ctrl pwk_checker u_chk (
    .clk(clk), .rst(rst), .osc_en(osc_en), .pll_en(pll_en),
    .cpu_run(cpu_run), .wake_irq(wake_irq), .wake_status(wake_status)
);

// File: tb/pwrdn_wake_ctrl_bench.sv
module pwrdn_wake_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAXW = 200;

    logic        clk = 0, rst = 1;
    logic        reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [15:0] reg_wdata = 0;
    logic        bus_active = 0, wake_pin = 1, wake2_pin = 1;
    logic        osc_stable = 0, pll_lock = 0;
    logic        osc_en, pll_en, cpu_run, wake_irq;
    logic [2:0]  wake_status;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_wake_ctrl u_pwrdn_wake_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .bus_active(bus_active), .wake_pin(wake_pin),
        .wake2_pin(wake2_pin), .osc_stable(osc_stable), .pll_lock(pll_lock),
        .osc_en(osc_en), .pll_en(pll_en), .cpu_run(cpu_run),
        .wake_irq(wake_irq), .wake_status(wake_status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_wait(input int lim, input bit ready);
        if (ready) return 1;
        return (lim < 1) ? 1 : lim;
    endfunction

    function automatic int exp_latency(input int src);
        return (src == 0) ? 1 : 3;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive one source to its active or idle level
    task automatic drive(input int src, input bit act, input bit hi1, input bit hi2);
        case (src)
            0: bus_active = act;
            1: wake_pin   = hi1 ? act : ~act;
            default: wake2_pin = hi2 ? act : ~act;
        endcase
    endtask

    task automatic one_wake(input int src, input int lo, input int lp,
                            input bit stab, input bit lock, input bit hi1, input bit hi2);
        int n, m, p;
        drive(0, 0, hi1, hi2); drive(1, 0, hi1, hi2); drive(2, 0, hi1, hi2);
        wr(3'd1, 16'((1 << src) | (hi1 << 4) | (hi2 << 5)));
        wr(3'd3, 16'(lo));
        wr(3'd4, 16'(lp));
        osc_stable = stab; pll_lock = lock;
        idle(3);
        wr(3'd0, 16'h0001);
        chk(!osc_en && !pll_en && !cpu_run, "R2 power-down", {osc_en, pll_en, cpu_run}, 0);
        drive(src, 1, hi1, hi2);
        n = 0;
        do begin @(negedge clk); n++; end while (!osc_en && n < MAXW);
        chk(n == exp_latency(src), "R11 wake latency", n, exp_latency(src));
        m = 0;
        while (!pll_en && m < MAXW) begin @(negedge clk); m++; end
        chk(m == exp_wait(lo, stab), "R4 osc wait", m, exp_wait(lo, stab));
        p = 0;
        while (!wake_irq && p < MAXW) begin @(negedge clk); p++; end
        chk(p == exp_wait(lp, lock), "R5 pll wait", p, exp_wait(lp, lock));
        chk(cpu_run && wake_status == 3'(1 << src), "R9 R6 R7 status",
            wake_status, 1 << src);
        @(negedge clk);
        chk(!wake_irq && cpu_run, "R3 irq one cycle", wake_irq, 0);
        drive(src, 0, hi1, hi2);
        wr(3'd2, 16'h0007);
        chk(wake_status == 0, "R9 clear", wake_status, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        int n;
        seed = 32'd1357;
        void'($urandom(seed));
        idle(2);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(osc_en && pll_en && cpu_run && !wake_irq, "R1 reset outputs",
            {osc_en, pll_en, cpu_run, wake_irq}, 4'b1110);
        chk(wake_status == 0, "R1 reset status", wake_status, 0);

        // R2 write with bit0 clear does nothing
        wr(3'd0, 16'h0002);
        idle(2);
        chk(osc_en && cpu_run, "R2 bit0 zero ignored", cpu_run, 1);

        // R7 reset polarity: enable pin only, pin low should wake
        wr(3'd1, 16'h0002);
        wake_pin = 1; idle(3);
        wr(3'd0, 16'h0001);
        wake_pin = 0;
        n = 0;
        do begin @(negedge clk); n++; end while (!osc_en && n < MAXW);
        chk(n == 3, "R7 default active low", n, 3);
        while (!cpu_run && n < MAXW) begin @(negedge clk); n++; end
        wake_pin = 1; wr(3'd2, 16'h0007);

        // random sweeps
        for (int k = 0; k < 40; k++) begin
            one_wake($urandom_range(0, 2), $urandom_range(0, 6), $urandom_range(0, 6),
                     $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                     $urandom_range(0, 1), $urandom_range(0, 1));
        end

        // R6 disabled source: pin active but enable off
        osc_stable = 1; pll_lock = 1;
        wr(3'd1, 16'h0001);
        wake_pin = 0; wake2_pin = 0; idle(3);
        wr(3'd0, 16'h0001);
        idle(10);
        chk(!osc_en, "R6 disabled pin no wake", osc_en, 0);
        // R8 gpio mode: pin2 enabled but in gpio mode, held active
        wr(3'd1, 16'h0045);
        idle(10);
        chk(!osc_en && wake_status == 0, "R8 gpio no wake", osc_en, 0);
        bus_active = 1;
        idle(5);
        chk(cpu_run && wake_status == 3'b001, "R8 gpio not recorded", wake_status, 1);
        bus_active = 0; wake_pin = 1; wake2_pin = 1;
        wr(3'd2, 16'h0007);

        // R9 two sources at once, then partial clear
        wr(3'd1, 16'h0006);
        idle(3);
        wr(3'd0, 16'h0001);
        wake_pin = 0; wake2_pin = 0;
        idle(8);
        chk(cpu_run && wake_status == 3'b110, "R9 both pins recorded", wake_status, 6);
        wake_pin = 1; wake2_pin = 1;
        wr(3'd2, 16'h0002);
        chk(wake_status == 3'b100, "R9 partial clear", wake_status, 4);
        wr(3'd2, 16'h0004);

        // R10 source already active at power-down request
        wr(3'd1, 16'h0001);
        bus_active = 1;
        wr(3'd0, 16'h0001);
        chk(!osc_en, "R10 enters power-down", osc_en, 0);
        @(negedge clk);
        chk(osc_en, "R10 one-cycle sleep", osc_en, 1);
        idle(4);
        chk(cpu_run && wake_status == 3'b001, "R10 wake recorded", wake_status, 1);
        bus_active = 0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule